// File: doc/BRIEF.md
# Serial Register Interface with Configuration Actions

This block is a four-wire serial slave (chip select, serial clock, data in, data out) that runs on the chip's system clock. It oversamples the serial pins and assembles 16-bit words while chip select is low. Each word holds a read/write flag, a 7-bit register address and one data byte. A frame takes effect only if exactly sixteen serial clocks arrived before chip select returned high. It then updates a 128-entry byte register file or the configuration register.

The configuration register drives the shutdown, lock, blink-rate and display-mode outputs. Two of its bits are not stored. They request one-shot actions that fire when the frame ends: clearing the digit/annunciator area of the register file and a pulse that resynchronises the external blink counters. Reads return the addressed byte on the data output during the second byte of the same frame. On a configuration read, the top bit is the live blink phase supplied from outside. The data output has an enable that is high only while a frame is in progress, so a shared line can be released.

The frame engine is a state machine with five states. **IDLE** is the wait for chip select. **HEADER** takes in the flag and the address. **PAYLOAD** takes in the data byte. **COMPLETE** means exactly sixteen clocks have been seen. **OVERRUN** means more than sixteen. The transitions are: *start* (chip select falls, IDLE to HEADER); *header_done* (eighth serial clock, HEADER to PAYLOAD); *payload_done* (sixteenth clock, PAYLOAD to COMPLETE); *overrun* (another clock in COMPLETE, COMPLETE to OVERRUN); and *end* (chip select rises, any state to IDLE). The word commits only on *end* leaving COMPLETE.

Top module: `serial_cfg_regif`

## Requirements
- R1: A frame is shifted in MSB first on serial clock rising edges. Bit 15 is the direction (0 = write, 1 = read), bits 14:8 are the address and bits 7:0 are the data. A write becomes visible only after chip select rises.
- R2: A frame with fewer or more than 16 serial clocks while chip select is low changes no register, output or strobe.
- R3: On a read, the addressed byte appears on `dout` MSB first, one bit per serial clock during clocks 9 to 16, valid at each rising edge. `dout_en` is 1 while chip select is low and 0 while it is high.
- R4: The configuration register is at address 0x04. Bit 0 drives `cfg_normal` (1 = normal operation, 0 = shutdown). Bit 1 drives `cfg_locked`. Bit 2 drives `cfg_blink_fast`. Bit 6 drives `cfg_mode_wide` (1 = two digits per grid, 96 digits). These outputs change only after a frame ends.
- R5: While `cfg_locked` is 1, a configuration write whose bit 1 is 1 is ignored entirely, including its actions. A configuration write whose bit 1 is 0 is applied in full. Writes to every other address still work.
- R6: An accepted configuration write with bit 5 set gives a one-cycle `digit_clr_stb` pulse after chip select rises. It also zeroes all registers from 0x20 to 0x7F and leaves 0x00 to 0x1F unchanged.
- R7: An accepted configuration write with bit 4 set gives a one-cycle `blink_sync_stb` pulse after chip select rises and does not clear registers.
- R8: A configuration read returns the `blink_phase` input in bit 7, bits 6 and 3:0 as last accepted, and bits 5 and 4 as 0. Writing bit 7 has no effect.
- R9: After reset, all registers and the configuration byte are 0, the strobes are 0 and `dout_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock |
| din | input | 1 | Serial data into the block |
| blink_phase | input | 1 | Live blink phase from the blink timer |
| dout | output | 1 | Serial data out of the block |
| dout_en | output | 1 | Output enable for the `dout` pad driver |
| cfg_normal | output | 1 | 1 = normal operation, 0 = shutdown |
| cfg_locked | output | 1 | Configuration lock state |
| cfg_blink_fast | output | 1 | Fast blink rate selected |
| cfg_mode_wide | output | 1 | Two digits per grid |
| digit_clr_stb | output | 1 | Pulse: digit data cleared |
| blink_sync_stb | output | 1 | Pulse: clear the blink counters |

## Verification
The hardest case to reach is a configuration word that is fully formed and carries an action bit but must not take effect. This happens when it arrives one clock short or one clock long, or while the lock is set. The stimulus builds these frames with an exact clock count and with the lock engaged beforehand. It then reads the cleared and uncleared ranges back over the serial port, and counts strobe cycles to show that nothing fired. The live phase bit is toggled between two configuration reads so the merged readback is seen in both states.

// File: rtl/sci_pkg.sv
package sci_pkg;

    localparam int ADDR_W  = 7;
    localparam int DATA_W  = 8;
    localparam int FRAME_W = ADDR_W + 1 + DATA_W;
    localparam int HDR_W   = ADDR_W + 1;

    // configuration bit positions (decoded by neighbours, so fixed)
    localparam int CB_RUN   = 0;
    localparam int CB_LOCK  = 1;
    localparam int CB_RATE  = 2;
    localparam int CB_SPARE = 3;
    localparam int CB_SYNC  = 4;
    localparam int CB_CLEAR = 5;
    localparam int CB_MODE  = 6;
    localparam int CB_PHASE = 7;

    // bits that are held in the configuration register
    localparam logic [DATA_W-1:0] CFG_KEEP =
        DATA_W'((1 << CB_RUN) | (1 << CB_LOCK) | (1 << CB_RATE) |
                (1 << CB_SPARE) | (1 << CB_MODE));

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HEADER,
        ST_PAYLOAD,
        ST_COMPLETE,
        ST_OVERRUN
    } frame_st_e;

endpackage

// File: rtl/sci_sync.sv
module sci_sync #(
    parameter int          W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    generate
        for (genvar g = 0; g < W; g++) begin : g_bit
            logic s1_q, s2_q, s3_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    s1_q <= RST_VAL[g];
                    s2_q <= RST_VAL[g];
                    s3_q <= RST_VAL[g];
                end else begin
                    s1_q <= pin_in[g];
                    s2_q <= s1_q;
                    s3_q <= s2_q;
                end
            end
            assign lvl[g]  = s2_q;
            assign rise[g] = s2_q & ~s3_q;
            assign fall[g] = ~s2_q & s3_q;
        end
    endgenerate
endmodule

// File: rtl/sci_frame.sv
module sci_frame
    import sci_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_fall,
    input  logic                cs_rise,
    input  logic                sclk_rise,
    input  logic                sclk_fall,
    input  logic                din_s,
    input  logic [DATA_W-1:0]   rd_data,
    output logic [ADDR_W-1:0]   rd_addr,
    output logic [FRAME_W-1:0]  word,
    output logic                commit,
    output logic                dout,
    output logic                dout_en
);
    localparam int CNT_W = $clog2(FRAME_W + 2);

    frame_st_e          st_q, st_d;
    logic [CNT_W-1:0]   cnt_q;
    logic [FRAME_W-1:0] rx_q;
    logic [DATA_W-1:0]  tx_q;
    logic               commit_q;
    logic               hdr_last, pay_last, rd_req;

    assign hdr_last = sclk_rise && (cnt_q == CNT_W'(HDR_W - 1));
    assign pay_last = sclk_rise && (cnt_q == CNT_W'(FRAME_W - 1));
    // address becomes complete with the bit arriving on this edge
    assign rd_addr  = {rx_q[ADDR_W-2:0], din_s};
    assign rd_req   = rx_q[ADDR_W-1];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // transitions: start, header_done, payload_done, overrun, end
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:     if (cs_fall)       st_d = ST_HEADER;
            ST_HEADER:   if (cs_rise)       st_d = ST_IDLE;
                         else if (hdr_last) st_d = ST_PAYLOAD;
            ST_PAYLOAD:  if (cs_rise)       st_d = ST_IDLE;
                         else if (pay_last) st_d = ST_COMPLETE;
            ST_COMPLETE: if (cs_rise)       st_d = ST_IDLE;
                         else if (sclk_rise) st_d = ST_OVERRUN;
            ST_OVERRUN:  if (cs_rise)       st_d = ST_IDLE;
            default:                        st_d = ST_IDLE;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            rx_q     <= '0;
            tx_q     <= '0;
            commit_q <= 1'b0;
        end else begin
            commit_q <= (st_q == ST_COMPLETE) && cs_rise;
            unique case (st_q)
                ST_IDLE: begin
                    if (cs_fall) begin
                        cnt_q <= '0;
                        tx_q  <= '0;
                    end
                end
                ST_HEADER: begin
                    if (sclk_rise && !cs_rise) begin
                        rx_q  <= {rx_q[FRAME_W-2:0], din_s};
                        cnt_q <= cnt_q + 1'b1;
                        if (hdr_last)
                            tx_q <= rd_req ? rd_data : '0;
                    end
                end
                ST_PAYLOAD: begin
                    if (sclk_rise && !cs_rise) begin
                        rx_q  <= {rx_q[FRAME_W-2:0], din_s};
                        cnt_q <= cnt_q + 1'b1;
                    end
                    // first payload bit is already on the line: shift from the 2nd
                    if (sclk_fall && cnt_q > CNT_W'(HDR_W))
                        tx_q <= {tx_q[DATA_W-2:0], 1'b0};
                end
                ST_COMPLETE, ST_OVERRUN: ;
                default: ;
            endcase
        end
    end

    assign word    = rx_q;
    assign commit  = commit_q;
    assign dout    = tx_q[DATA_W-1];
    assign dout_en = (st_q != ST_IDLE);
endmodule

// File: rtl/sci_regfile.sv
module sci_regfile
    import sci_pkg::*;
#(
    parameter logic [ADDR_W-1:0] CFG_ADDR = 7'h04,
    parameter int                CLR_LO   = 'h20,
    parameter int                CLR_HI   = 'h7F
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               commit,
    input  logic [FRAME_W-1:0] word,
    input  logic [ADDR_W-1:0]  rd_addr,
    input  logic               blink_phase,
    output logic [DATA_W-1:0]  rd_data,
    output logic [DATA_W-1:0]  cfg,
    output logic               clr_stb,
    output logic               sync_stb
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] cfg_q;
    logic              clr_q, sync_q;
    logic              wr, cfg_hit, accept;
    logic [ADDR_W-1:0] wa;
    logic [DATA_W-1:0] wd;

    assign wr      = commit && !word[FRAME_W-1];
    assign wa      = word[FRAME_W-2:DATA_W];
    assign wd      = word[DATA_W-1:0];
    assign cfg_hit = (wa == CFG_ADDR);
    assign accept  = !cfg_q[CB_LOCK] || !wd[CB_LOCK];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            clr_q  <= 1'b0;
            sync_q <= 1'b0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            clr_q  <= 1'b0;
            sync_q <= 1'b0;
            if (wr && cfg_hit) begin
                if (accept) begin
                    cfg_q  <= wd & CFG_KEEP;
                    clr_q  <= wd[CB_CLEAR];
                    sync_q <= wd[CB_SYNC];
                    if (wd[CB_CLEAR])
                        for (int i = CLR_LO; i <= CLR_HI; i++) mem_q[i] <= '0;
                end
            end else if (wr) begin
                mem_q[wa] <= wd;
            end
        end
    end

    always_comb begin
        if (rd_addr == CFG_ADDR) begin
            rd_data           = cfg_q;
            rd_data[CB_PHASE] = blink_phase;
        end else begin
            rd_data = mem_q[rd_addr];
        end
    end

    assign cfg      = cfg_q;
    assign clr_stb  = clr_q;
    assign sync_stb = sync_q;
endmodule

// File: rtl/serial_cfg_regif.sv
module serial_cfg_regif
    import sci_pkg::*;
#(
    parameter logic [ADDR_W-1:0] CFG_ADDR = 7'h04,
    parameter int                CLR_LO   = 'h20,
    parameter int                CLR_HI   = 'h7F
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic din,
    input  logic blink_phase,
    output logic dout,
    output logic dout_en,
    output logic cfg_normal,
    output logic cfg_locked,
    output logic cfg_blink_fast,
    output logic cfg_mode_wide,
    output logic digit_clr_stb,
    output logic blink_sync_stb
);
    logic [2:0]         lvl, rise, fall;
    logic [DATA_W-1:0]  rd_data, cfg;
    logic [ADDR_W-1:0]  rd_addr;
    logic [FRAME_W-1:0] word;
    logic               commit;

    // bit 0: cs_n, bit 1: sclk, bit 2: din
    sci_sync #(.W(3), .RST_VAL(3'b001)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in ({din, sclk, cs_n}),
        .lvl    (lvl),
        .rise   (rise),
        .fall   (fall)
    );

    sci_frame u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_fall   (fall[0]),
        .cs_rise   (rise[0]),
        .sclk_rise (rise[1]),
        .sclk_fall (fall[1]),
        .din_s     (lvl[2]),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .word      (word),
        .commit    (commit),
        .dout      (dout),
        .dout_en   (dout_en)
    );

    sci_regfile #(.CFG_ADDR(CFG_ADDR), .CLR_LO(CLR_LO), .CLR_HI(CLR_HI)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .commit      (commit),
        .word        (word),
        .rd_addr     (rd_addr),
        .blink_phase (blink_phase),
        .rd_data     (rd_data),
        .cfg         (cfg),
        .clr_stb     (digit_clr_stb),
        .sync_stb    (blink_sync_stb)
    );

    assign cfg_normal     = cfg[CB_RUN];
    assign cfg_locked     = cfg[CB_LOCK];
    assign cfg_blink_fast = cfg[CB_RATE];
    assign cfg_mode_wide  = cfg[CB_MODE];

    logic unused_ok;
    assign unused_ok = ^{lvl[1:0], rise[2], fall[2], cfg[CB_SPARE], cfg[CB_SYNC], cfg[CB_CLEAR], cfg[CB_PHASE]};
endmodule

// File: rtl/serial_cfg_regif_chk.sv
module serial_cfg_regif_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic dout_en,
    input logic cfg_normal,
    input logic cfg_locked,
    input logic cfg_blink_fast,
    input logic cfg_mode_wide,
    input logic digit_clr_stb,
    input logic blink_sync_stb
);
    p_clr_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        digit_clr_stb |=> !digit_clr_stb);

    p_sync_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        blink_sync_stb |=> !blink_sync_stb);

    p_clr_after_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
        digit_clr_stb |-> $past(cs_n));

    p_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !dout_en);

    p_lock_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_locked && $past(cfg_locked)) |->
            ($stable(cfg_normal) && $stable(cfg_blink_fast) && $stable(cfg_mode_wide)));

    p_cfg_at_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(cfg_normal) || !$stable(cfg_mode_wide) || !$stable(cfg_blink_fast)) |-> $past(cs_n));
endmodule

bind serial_cfg_regif serial_cfg_regif_chk u_chk (.*);

// File: tb/sim_serial_cfg_regif.sv
`timescale 1ns/1ps
module sim_serial_cfg_regif;
    localparam int HALF = 8;
    localparam logic [6:0] CFG = 7'h04;

    logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, din = 1'b0, blink_phase = 1'b0;
    logic dout, dout_en, cfg_normal, cfg_locked, cfg_blink_fast, cfg_mode_wide;
    logic digit_clr_stb, blink_sync_stb;

    int checks = 0, errors = 0;
    int clr_cnt = 0, sync_cnt = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    serial_cfg_regif u0 (.*);

    typedef struct { logic [7:0] exp; string req; } exp_t;
    exp_t sb_q[$];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // strobe monitor: counts high cycles
    always @(negedge clk) begin
        if (digit_clr_stb)  clr_cnt++;
        if (blink_sync_stb) sync_cnt++;
    end

    // serial monitor / scoreboard
    int mon_bits = 0;
    logic [15:0] mon_mosi = '0;
    logic [7:0]  mon_miso = '0;
    always @(negedge cs_n) mon_bits = 0;
    always @(posedge sclk) if (!cs_n) begin
        mon_mosi = {mon_mosi[14:0], din};
        if (mon_bits >= 8) mon_miso = {mon_miso[6:0], dout};
        mon_bits++;
    end
    always @(posedge cs_n) if (mon_bits == 16 && mon_mosi[15]) begin
        exp_t e;
        if (sb_q.size() == 0) begin
            chk(1'b0, "R3 (no expected item)", 32'(mon_miso), 32'hx);
        end else begin
            e = sb_q.pop_front();
            chk(mon_miso === e.exp, e.req, 32'(mon_miso), 32'(e.exp));
        end
    end

    task automatic xfer(input bit rw, input logic [6:0] a, input logic [7:0] d, input int n);
        logic [15:0] w;
        w = {rw, a, d};
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            din = (i < 16) ? w[15-i] : 1'b0;
            repeat (HALF) @(negedge clk);
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (6 * HALF) @(negedge clk);
    endtask

    task automatic wr(input logic [6:0] a, input logic [7:0] d);
        xfer(1'b0, a, d, 16);
    endtask

    task automatic rd(input logic [6:0] a, input logic [7:0] e, input string req);
        exp_t it;
        it.exp = e;
        it.req = req;
        sb_q.push_back(it);
        xfer(1'b1, a, 8'h00, 16);
    endtask

    task automatic chk_cfg(input logic [3:0] e, input string req);
        logic [3:0] a;
        a = {cfg_mode_wide, cfg_blink_fast, cfg_locked, cfg_normal};
        chk(a === e, req, 32'(a), 32'(e));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog", 32'(checks), 32'h0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int c0, s0;
        repeat (4) @(negedge clk);
        // R9: reset state
        chk(dout_en === 1'b0, "R9 dout_en at reset", 32'(dout_en), 0);
        chk_cfg(4'b0000, "R9 cfg outputs at reset");
        chk({digit_clr_stb, blink_sync_stb} === 2'b00, "R9 strobes at reset", 32'({digit_clr_stb, blink_sync_stb}), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        rd(7'h10, 8'h00, "R9 register zero after reset");

        // R3: output enable follows chip select
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        chk(dout_en === 1'b1, "R3 dout_en while selected", 32'(dout_en), 1);
        cs_n = 1'b1;
        repeat (6 * HALF) @(negedge clk);
        chk(dout_en === 1'b0, "R3 dout_en after deselect", 32'(dout_en), 0);

        // R1 / R3: writes and read-back
        wr(7'h10, 8'hA5);
        wr(7'h30, 8'h3C);
        wr(7'h7F, 8'h81);
        wr(7'h1F, 8'h55);
        rd(7'h10, 8'hA5, "R1 read 0x10");
        rd(7'h30, 8'h3C, "R3 read 0x30");
        rd(7'h7F, 8'h81, "R1 read 0x7F");

        // R2: bad frame lengths
        xfer(1'b0, 7'h10, 8'h00, 15);
        rd(7'h10, 8'hA5, "R2 short frame discarded");
        xfer(1'b0, 7'h10, 8'h00, 17);
        rd(7'h10, 8'hA5, "R2 long frame discarded");

        // R4 / R8: configuration
        wr(CFG, 8'hC5);
        chk_cfg(4'b1101, "R4 cfg outputs after 0xC5");
        blink_phase = 1'b1;
        rd(CFG, 8'hC5, "R8 cfg read with phase 1");
        blink_phase = 1'b0;
        rd(CFG, 8'h45, "R8 cfg read with phase 0, bit 7 not stored");

        // R5: lock
        wr(CFG, 8'h47);
        chk_cfg(4'b1111, "R5 lock set");
        c0 = clr_cnt;
        wr(CFG, 8'h22);
        chk_cfg(4'b1111, "R5 locked write ignored");
        chk(clr_cnt == c0, "R5 locked write fires no clear", 32'(clr_cnt - c0), 0);
        rd(7'h30, 8'h3C, "R5 locked clear request left data");
        wr(7'h10, 8'h77);
        rd(7'h10, 8'h77, "R5 other registers writable while locked");
        wr(CFG, 8'h01);
        chk_cfg(4'b0001, "R5 unlock write applied in full");

        // R2: short frame carrying a clear request
        c0 = clr_cnt;
        xfer(1'b0, CFG, 8'h21, 15);
        chk(clr_cnt == c0, "R2 short cfg frame fires nothing", 32'(clr_cnt - c0), 0);

        // R6: digit clear
        c0 = clr_cnt; s0 = sync_cnt;
        wr(CFG, 8'h21);
        chk(clr_cnt - c0 == 1, "R6 one-cycle clear strobe", 32'(clr_cnt - c0), 1);
        chk(sync_cnt == s0, "R6 no sync strobe", 32'(sync_cnt - s0), 0);
        rd(7'h30, 8'h00, "R6 0x30 cleared");
        rd(7'h7F, 8'h00, "R6 0x7F cleared");
        rd(7'h1F, 8'h55, "R6 0x1F kept");
        rd(7'h10, 8'h77, "R6 0x10 kept");
        rd(CFG, 8'h01, "R8 action bit reads 0");

        // R7: blink sync
        wr(7'h40, 8'h99);
        c0 = clr_cnt; s0 = sync_cnt;
        wr(CFG, 8'h11);
        chk(sync_cnt - s0 == 1, "R7 one-cycle sync strobe", 32'(sync_cnt - s0), 1);
        chk(clr_cnt == c0, "R7 no clear strobe", 32'(clr_cnt - c0), 0);
        rd(7'h40, 8'h99, "R7 data not cleared");
        rd(CFG, 8'h01, "R8 sync bit reads 0");

        repeat (10) @(negedge clk);
        chk(sb_q.size() == 0, "R3 all reads observed", 32'(sb_q.size()), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule